// File: doc/BRIEF.md
# Serial Flash Quad-Enable Init Sequencer

This block runs once after reset. It prepares an external serial NOR flash for four-lane reads and must finish before the fast read path is released. When it receives a start pulse, it uses a single-lane SPI master port to read the flash's second status register and test its quad-enable flag. If the flag is already set, the block finishes after that single read. If the flag is clear, the block sends a write-enable command, then a status write that carries the values for both status registers. After that it polls the busy flag of the first status register until the internal write cycle ends.

The block's outputs report the result. `done_o` means the flash is ready. `err_o` means the busy flag did not clear within the poll budget. Both flags stay set until the next reset or start pulse.

Top module: `qe_init_seq`

## Requirements
- R1: After reset `cs_no` is high, `sck_o` is low, and `done_o` and `err_o` are low. No frame is sent until `start_i` is pulsed.
- R2: The first frame is two bytes: the command 0x35 and then one dummy byte. Bytes are sent MSB first in SPI mode 0: `sck_o` idles low, `miso_i` is sampled on the rising edge, and `mosi_o` changes on the falling edge.
- R3: Bit 1 of the byte read back in the first frame is the quad-enable flag, and only that bit is tested. If it is 1, the sequence ends after that single frame, with `done_o` high and `err_o` low.
- R4: If bit 1 is 0, the next frame holds only the command 0x06. The frame after it is three bytes: 0x01, 0x00, 0x02.
- R5: After the status write, the block sends frames of 0x05 plus one dummy byte. It stops when bit 0 of the returned byte is 0, and then raises `done_o`.
- R6: If bit 0 still reads 1 after MAX_POLLS poll frames, `err_o` goes high and `done_o` stays low, with no further frames.
- R7: Each high and each low phase of `sck_o` inside a byte lasts CLK_DIV/2 clock cycles. CLK_DIV must be an even number of at least 2.
- R8: Between frames, `cs_no` stays high for at least CLK_DIV clock cycles. `sck_o` is low whenever `cs_no` changes.
- R9: `done_o` and `err_o` hold their value until a new `start_i` clears them and restarts the sequence. A `start_i` pulse that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts the sequence |
| miso_i | input | 1 | Serial data from the flash |
| cs_no | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the flash |
| done_o | output | 1 | Flash is ready for quad reads (sticky) |
| err_o | output | 1 | Busy-poll budget ran out (sticky) |

## Verification
A behavioural flash model answers the status reads. The bench gives it second-status values that separate the two branches:
- 0x02 and 0x03 must skip the write.
- 0x00 and 0xFD must trigger it. These two values show that only bit 1 is tested, not the whole byte.

Busy counts of 0, 3 and MAX_POLLS-1 must end with done after exactly busy+1 polls. A busy count of MAX_POLLS must end with the error flag. For every run, the bench also checks the command frames it logged: each command byte, frame length and data byte, along with the clock phase widths and the chip-select gaps.

// File: rtl/qe_init_pkg.sv
package qe_init_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_RD_SR2 = 8'h35;
  localparam logic [BYTE_W-1:0] CMD_WREN   = 8'h06;
  localparam logic [BYTE_W-1:0] CMD_WR_SR  = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_RD_SR1 = 8'h05;
  localparam logic [BYTE_W-1:0] SR1_VAL    = 8'h00;
  localparam logic [BYTE_W-1:0] SR2_VAL    = 8'h02;
  localparam int QE_BIT   = 1;
  localparam int BUSY_BIT = 0;

  typedef enum logic [1:0] {
    FR_RD_SR2,
    FR_WREN,
    FR_WR_SR,
    FR_POLL
  } frame_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_GAP,
    ST_DONE,
    ST_ERR
  } seq_st_e;

  function automatic logic [1:0] frame_last(frame_e fr);
    case (fr)
      FR_RD_SR2: return 2'd1;
      FR_WREN:   return 2'd0;
      FR_WR_SR:  return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] frame_byte(frame_e fr, logic [1:0] idx);
    case (fr)
      FR_RD_SR2: return (idx == 2'd0) ? CMD_RD_SR2 : '0;
      FR_WREN:   return CMD_WREN;
      FR_WR_SR:  return (idx == 2'd0) ? CMD_WR_SR : (idx == 2'd1) ? SR1_VAL : SR2_VAL;
      default:   return (idx == 2'd0) ? CMD_RD_SR1 : '0;
    endcase
  endfunction
endpackage

// File: rtl/qe_spi_byte.sv
module qe_spi_byte
  import qe_init_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              done_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic              busy_q, sck_q, done_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          sh_q   <= tx_i;
          div_q  <= '0;
          bit_q  <= '0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sck_q) begin
          // rising edge: sample
          sck_q <= 1'b1;
          rx_q  <= {rx_q[BYTE_W-2:0], miso_i};
        end else begin
          // falling edge: advance
          sck_q <= 1'b0;
          if (bit_q == BIT_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sh_q[BYTE_W-1];
  assign rx_o   = rx_q;
  assign done_o = done_q;
endmodule

// File: rtl/qe_init_fsm.sv
module qe_init_fsm
  import qe_init_pkg::*;
#(
  parameter int MAX_POLLS = 64,
  parameter int GAP_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] rx_i,
  output logic              go_o,
  output logic [BYTE_W-1:0] tx_o,
  output logic              cs_no,
  output logic              done_o,
  output logic              err_o
);
  localparam int PC_W  = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [PC_W-1:0]  POLL_LAST = PC_W'(MAX_POLLS - 1);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_CYC - 1);

  seq_st_e          st_q;
  frame_e           fr_q;
  logic [1:0]       idx_q;
  logic             issued_q;
  logic [GAP_W-1:0] gap_q;
  logic [PC_W-1:0]  pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      fr_q     <= FR_RD_SR2;
      idx_q    <= '0;
      issued_q <= 1'b0;
      gap_q    <= '0;
      pc_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start_i) begin
            st_q     <= ST_FRAME;
            fr_q     <= FR_RD_SR2;
            idx_q    <= '0;
            issued_q <= 1'b0;
          end
        end
        ST_FRAME: begin
          if (!issued_q) begin
            issued_q <= 1'b1;
          end else if (byte_done_i) begin
            issued_q <= 1'b0;
            if (idx_q == frame_last(fr_q)) begin
              st_q  <= ST_GAP;
              gap_q <= '0;
              idx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) begin
            st_q     <= ST_FRAME;
            issued_q <= 1'b0;
            case (fr_q)
              FR_RD_SR2: begin
                if (rx_i[QE_BIT]) st_q <= ST_DONE;
                else              fr_q <= FR_WREN;
              end
              FR_WREN: fr_q <= FR_WR_SR;
              FR_WR_SR: begin
                fr_q <= FR_POLL;
                pc_q <= '0;
              end
              default: begin
                if (!rx_i[BUSY_BIT])        st_q <= ST_DONE;
                else if (pc_q == POLL_LAST) st_q <= ST_ERR;
                else                        pc_q <= pc_q + 1'b1;
              end
            endcase
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign go_o   = (st_q == ST_FRAME) && !issued_q;
  assign tx_o   = frame_byte(fr_q, idx_q);
  assign cs_no  = (st_q != ST_FRAME);
  assign done_o = (st_q == ST_DONE);
  assign err_o  = (st_q == ST_ERR);
endmodule

// File: rtl/qe_init_seq.sv
module qe_init_seq
  import qe_init_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int MAX_POLLS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic miso_i,
  output logic cs_no,
  output logic sck_o,
  output logic mosi_o,
  output logic done_o,
  output logic err_o
);
  localparam int GAP_CYC = CLK_DIV;

  generate
    if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and >= 2");
    end
    if (MAX_POLLS < 1) begin : g_bad_polls
      $error("MAX_POLLS must be >= 1");
    end
  endgenerate

  logic              go;
  logic              byte_done;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  qe_init_fsm #(
    .MAX_POLLS(MAX_POLLS),
    .GAP_CYC  (GAP_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .byte_done_i(byte_done),
    .rx_i       (rx_byte),
    .go_o       (go),
    .tx_o       (tx_byte),
    .cs_no      (cs_no),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  qe_spi_byte #(
    .CLK_DIV(CLK_DIV)
  ) u_spi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .tx_i  (tx_byte),
    .miso_i(miso_i),
    .sck_o (sck_o),
    .mosi_o(mosi_o),
    .rx_o  (rx_byte),
    .done_o(byte_done)
  );
endmodule

// File: rtl/qe_init_chk.sv
module qe_init_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_no,
  input logic sck_o,
  input logic done_o,
  input logic err_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(CLK_DIV + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sck_prev;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev <= 1'b0;
      run_cnt  <= '0;
    end else begin
      sck_prev <= sck_o;
      if (sck_o != sck_prev)   run_cnt <= CNT_W'(1);
      else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
    end
  end

  // R7
  sck_high_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> run_cnt == CNT_W'(HALF));

  // R8
  cs_edge_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_no) || $fell(cs_no)) |-> !sck_o);

  // R2
  sck_only_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> !cs_no);

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

  // R3
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (cs_no && !sck_o));
endmodule

bind qe_init_seq qe_init_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .cs_no  (cs_no),
  .sck_o  (sck_o),
  .done_o (done_o),
  .err_o  (err_o)
);

// File: tb/sim_qe_init_seq.sv
`timescale 1ns/1ps
module sim_qe_init_seq;
  localparam int CLK_DIV   = 4;
  localparam int MAX_POLLS = 6;
  localparam int NVEC      = 7;
  localparam int LOGN      = 32;

  // {sr2_init[23:16], busy_polls[15:8], exp_frames[7:2], exp_done[1], exp_err[0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h02, 8'd0, 6'd1, 1'b1, 1'b0},
    {8'h03, 8'd0, 6'd1, 1'b1, 1'b0},
    {8'h00, 8'd0, 6'd4, 1'b1, 1'b0},
    {8'hFD, 8'd0, 6'd4, 1'b1, 1'b0},
    {8'h00, 8'd3, 6'd7, 1'b1, 1'b0},
    {8'h00, 8'd5, 6'd9, 1'b1, 1'b0},
    {8'h00, 8'd6, 6'd9, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic miso = 1'b0;
  logic cs_n, sck, mosi, done, err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  qe_init_seq #(.CLK_DIV(CLK_DIV), .MAX_POLLS(MAX_POLLS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .miso_i(miso),
    .cs_no(cs_n), .sck_o(sck), .mosi_o(mosi), .done_o(done), .err_o(err)
  );

  // flash model
  logic [7:0] m_sr1 = 8'h00, m_sr2 = 8'h00, m_rx = 8'h00, m_tx = 8'h00;
  logic [7:0] m_fb [4];
  int  m_bits = 0, m_bytes = 0, m_busy = 0, m_busy_cfg = 0;
  bit  m_wel = 0;
  int  n_fr = 0;
  logic [7:0] log_cmd [LOGN], log_b1 [LOGN], log_b2 [LOGN];
  int  log_len [LOGN];
  int  sck_bad = 0, gap_bad = 0, cs_sck_bad = 0, sck_run = 0, gap_run = 0;

  always @(negedge cs_n) begin
    m_bits = 0; m_bytes = 0; m_tx = 8'h00;
    if (sck !== 1'b0) cs_sck_bad++;
  end

  always @(posedge sck) if (!cs_n) begin
    m_rx = {m_rx[6:0], mosi};
    m_bits++;
    if (m_bits == 8) begin
      m_bits = 0;
      if (m_bytes < 4) m_fb[m_bytes] = m_rx;
      if (m_bytes == 0) begin
        case (m_rx)
          8'h35:   m_tx = m_sr2;
          8'h05:   m_tx = {7'b0, (m_busy != 0)};
          default: m_tx = 8'h00;
        endcase
      end
      m_bytes++;
    end
  end

  always @(negedge sck) if (!cs_n) begin
    miso = m_tx[7];
    m_tx = {m_tx[6:0], 1'b0};
  end

  always @(posedge cs_n) begin
    if (sck !== 1'b0) cs_sck_bad++;
    if (m_bytes > 0 && n_fr < LOGN) begin
      log_cmd[n_fr] = m_fb[0];
      log_len[n_fr] = m_bytes;
      log_b1[n_fr]  = m_fb[1];
      log_b2[n_fr]  = m_fb[2];
      if (m_fb[0] == 8'h06 && m_bytes == 1) m_wel = 1;
      if (m_fb[0] == 8'h01 && m_bytes == 3 && m_wel) begin
        m_sr1 = m_fb[1]; m_sr2 = m_fb[2]; m_busy = m_busy_cfg; m_wel = 0;
      end
      if (m_fb[0] == 8'h05 && m_busy > 0) m_busy--;
      n_fr++;
    end
  end

  // phase and gap monitors, sampled mid-cycle
  always @(negedge clk) begin
    if (sck) sck_run++;
    else begin
      if (sck_run != 0 && sck_run != CLK_DIV / 2) sck_bad++;
      sck_run = 0;
    end
    if (cs_n) gap_run++;
    else begin
      if (gap_run != 0 && n_fr > 0 && gap_run < CLK_DIV) gap_bad++;
      gap_run = 0;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog: actual %0d cycles, expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h, expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    while (!(done || err)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic prep(input logic [7:0] sr2, input int busy);
    m_sr2 = sr2; m_sr1 = 8'h00; m_busy_cfg = busy; m_busy = 0; m_wel = 0;
    n_fr = 0; sck_bad = 0; gap_bad = 0; cs_sck_bad = 0;
  endtask

  task automatic verify(input logic [23:0] v, input int idx);
    int  exp_n  = int'(v[7:2]);
    bit  skip   = (exp_n == 1);
    bit  seq_ok = 1;
    string tg   = v[0] ? "R6" : (skip ? "R3" : "R5");
    check(n_fr == exp_n, $sformatf("%s frame count vec%0d", tg, idx), n_fr, exp_n);
    check(done == v[1], $sformatf("%s done vec%0d", tg, idx), done, v[1]);
    check(err == v[0], $sformatf("R6 err vec%0d", idx), err, v[0]);
    check(log_cmd[0] == 8'h35 && log_len[0] == 2,
          $sformatf("R2 first frame vec%0d", idx), {log_cmd[0], 8'(log_len[0])}, 16'h3502);
    if (!skip && n_fr >= 3) begin
      check(log_cmd[1] == 8'h06 && log_len[1] == 1,
            $sformatf("R4 wren frame vec%0d", idx), {log_cmd[1], 8'(log_len[1])}, 16'h0601);
      check(log_cmd[2] == 8'h01 && log_len[2] == 3 && log_b1[2] == 8'h00 && log_b2[2] == 8'h02,
            $sformatf("R4 wrsr frame vec%0d", idx),
            {log_cmd[2], log_b1[2], log_b2[2]}, 24'h010002);
      for (int f = 3; f < n_fr && f < LOGN; f++)
        if (log_cmd[f] != 8'h05 || log_len[f] != 2) seq_ok = 0;
      check(seq_ok, $sformatf("R5 poll frames vec%0d", idx), seq_ok, 1);
      check(m_sr2 == 8'h02, $sformatf("R4 flash sr2 vec%0d", idx), m_sr2, 8'h02);
    end else begin
      check(m_sr2 == v[23:16], $sformatf("R3 sr2 untouched vec%0d", idx), m_sr2, v[23:16]);
    end
    check(sck_bad == 0, $sformatf("R7 sck phase vec%0d", idx), sck_bad, 0);
    check(gap_bad == 0 && cs_sck_bad == 0, $sformatf("R8 cs gap vec%0d", idx),
          gap_bad + cs_sck_bad, 0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sck === 1'b0, "R1 bus idle in reset", {cs_n, sck}, 2'b10);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(done === 1'b0 && err === 1'b0, "R1 flags low after reset", {done, err}, 0);
    check(n_fr == 0, "R1 no frame without start", n_fr, 0);

    for (int i = 0; i < NVEC; i++) begin
      prep(VEC[i][23:16], int'(VEC[i][15:8]));
      pulse_start();
      wait_end();
      verify(VEC[i], i);
    end

    // R6 err holds
    repeat (200) @(negedge clk);
    check(err === 1'b1 && cs_n === 1'b1, "R6 err sticky", {err, cs_n}, 2'b11);

    // R9 start mid-run ignored
    prep(8'h00, 3);
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    wait_end();
    check(n_fr == 7 && done === 1'b1, "R9 start ignored while running", n_fr, 7);

    // R9 done holds, start clears
    repeat (300) @(negedge clk);
    check(done === 1'b1 && cs_n === 1'b1, "R9 done sticky", {done, cs_n}, 2'b11);
    prep(8'h02, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done === 1'b0, "R9 start clears done", done, 0);
    wait_end();
    check(done === 1'b1 && n_fr == 1, "R9 rerun completes", n_fr, 1);

    summary();
    $finish;
  end
endmodule